// File: doc/BRIEF.md
# Dual-Clock Serial-to-Parallel Register with Holding Stage

This block turns a serial bit stream into a parallel word in two steps. A shift chain takes one bit per rising edge of its own clock. A separate storage register copies the whole chain on rising edges of a second, independent clock. The parallel outputs always come from the storage register. The word shown on them therefore stays steady while the next word is shifted in, and it changes only when software or a sequencer strobes the storage clock.

Each register has its own active-low clear. A clear takes effect at once, without waiting for a clock edge. Its release passes through a small synchronizer clocked by the register it controls, so leaving reset cannot produce a partial clock edge. A cascade output follows the last shift stage, so instances can be chained into wider words. When both clocks are driven from one net, the storage register takes the chain contents from just before the shared edge, so it stays one shift behind.

Top module: `dualclk_sipo`

## Requirements
- R1: With both clears low, `par_out` reads all zeros and `cas_out` reads 0.
- R2: On a rising `sh_clk` edge with the shift side out of reset, stage 0 takes `ser_in` and stage i takes the old value of stage i-1. Stage 0 is the least significant bit of the word that is later shown on `par_out`.
- R3: A falling edge of `sh_clk` or of `st_clk` changes neither `par_out` nor `cas_out`.
- R4: Pulling `sh_clr_n` low clears every shift stage at once, with no clock edge, so `cas_out` reads 0. `par_out` is not affected.
- R5: Pulling `st_clr_n` low sets `par_out` to zero at once, with no clock edge. The shift chain and `cas_out` keep their values.
- R6: On a rising `st_clk` edge with the storage side out of reset, all WIDTH bits of the shift chain are copied to `par_out`. `par_out` changes at no other time except a storage clear.
- R7: `cas_out` always equals shift stage WIDTH-1, whatever the storage register holds.
- R8: When `sh_clk` and `st_clk` rise together, `par_out` takes the chain contents from before that edge.
- R9: After a clear is released, the first SYNC_STAGES rising edges of that register's own clock (default 2) leave it at zero. The edge after those acts normally.
- R10: Two instances chained through `cas_out` into the next `ser_in`, with shared clocks and clears, behave as one 2*WIDTH-bit register. The first instance holds the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data bit, sampled by the shift clock |
| sh_clk | input | 1 | Shift clock, acts on its rising edge |
| sh_clr_n | input | 1 | Active-low clear of the shift chain |
| st_clk | input | 1 | Storage clock, acts on its rising edge |
| st_clr_n | input | 1 | Active-low clear of the storage register |
| par_out | output | WIDTH | Parallel word held in the storage register |
| cas_out | output | 1 | Last shift stage, for chaining |

## Verification
The bound checker checks on every cycle of its own clock: the one-step shift, the cascade output following the chain, the whole-word capture into storage, the zero held during and just after a clear, and the edges held off after a clear is released. Only the bench scenarios can show the following. A clear acts between clock edges. Falling edges do nothing. Tied clocks leave the storage one shift behind. Two chained instances form a single 16-bit word. Each scenario compares both outputs against a bench model that steps the shift and storage registers by hand.

// File: rtl/dualclk_sipo_pkg.sv
package dualclk_sipo_pkg;
   // default word width of one instance
   localparam int unsigned SIPO_DEF_WIDTH = 8;
   // default flop count of each clear-release synchronizer
   localparam int unsigned SIPO_DEF_SYNC  = 2;
   // upper bound kept small so a chain of flops stays tiny
   localparam int unsigned SIPO_MAX_SYNC  = 4;
endpackage

// File: rtl/dualclk_sipo_rstsync.sv
// Asserts its reset output as soon as clr_n falls; releases it only after
// STAGES rising edges of clk, so the release lines up with the clock.
module dualclk_sipo_rstsync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic clr_n,
   output logic rst_n
);
   generate
      if (STAGES == 0) begin : g_direct
         assign rst_n = clr_n;
      end else begin : g_chain
         logic [STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) begin
               sync_q <= '0;
            end else if (STAGES == 1) begin
               sync_q <= '1;
            end else begin
               sync_q <= {sync_q[STAGES-2:0], 1'b1};
            end
         end
         assign rst_n = sync_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/dualclk_sipo_shift.sv
// Serial-in chain; stage 0 takes din, stage i takes stage i-1.
module dualclk_sipo_shift #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         q <= {q[WIDTH-2:0], din};
      end
   end
endmodule

// File: rtl/dualclk_sipo_store.sv
// Holding register loaded from the whole shift chain at once.
module dualclk_sipo_store #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         q <= d;
      end
   end
endmodule

// File: rtl/dualclk_sipo.sv
module dualclk_sipo
   import dualclk_sipo_pkg::*;
#(
   parameter int unsigned WIDTH       = SIPO_DEF_WIDTH,
   parameter int unsigned SYNC_STAGES = SIPO_DEF_SYNC
) (
   input  logic             ser_in,
   input  logic             sh_clk,
   input  logic             sh_clr_n,
   input  logic             st_clk,
   input  logic             st_clr_n,
   output logic [WIDTH-1:0] par_out,
   output logic             cas_out
);
   localparam int unsigned LAST = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("dualclk_sipo: WIDTH must be at least 2");
      end
      if (SYNC_STAGES > SIPO_MAX_SYNC) begin : g_bad_sync
         $error("dualclk_sipo: SYNC_STAGES exceeds SIPO_MAX_SYNC");
      end
   endgenerate

   logic             sh_rst_n;
   logic             st_rst_n;
   logic [WIDTH-1:0] shift_q;

   dualclk_sipo_rstsync #(.STAGES(SYNC_STAGES)) u_sh_sync (
      .clk   (sh_clk),
      .clr_n (sh_clr_n),
      .rst_n (sh_rst_n)
   );

   dualclk_sipo_rstsync #(.STAGES(SYNC_STAGES)) u_st_sync (
      .clk   (st_clk),
      .clr_n (st_clr_n),
      .rst_n (st_rst_n)
   );

   dualclk_sipo_shift #(.WIDTH(WIDTH)) u_shift (
      .clk   (sh_clk),
      .rst_n (sh_rst_n),
      .din   (ser_in),
      .q     (shift_q)
   );

   dualclk_sipo_store #(.WIDTH(WIDTH)) u_store (
      .clk   (st_clk),
      .rst_n (st_rst_n),
      .d     (shift_q),
      .q     (par_out)
   );

   assign cas_out = shift_q[LAST];
endmodule

// File: rtl/dualclk_sipo_chk.sv
module dualclk_sipo_chk #(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic             sh_clk,
   input logic             st_clk,
   input logic             sh_clr_n,
   input logic             st_clr_n,
   input logic             ser_in,
   input logic             sh_rst_n,
   input logic             st_rst_n,
   input logic [WIDTH-1:0] sh_q,
   input logic [WIDTH-1:0] par_out,
   input logic             cas_out
);
   // R2: one-step shift between consecutive edges out of reset
   a_r2_shift_step: assert property (@(posedge sh_clk) disable iff (!sh_rst_n)
      $past(sh_rst_n) |-> sh_q == {$past(sh_q[WIDTH-2:0]), $past(ser_in)});

   // R7: cascade output follows the chain's top stage
   a_r7_cascade: assert property (@(posedge sh_clk) disable iff (!sh_rst_n)
      $past(sh_rst_n) |-> cas_out == $past(sh_q[WIDTH-2]));

   // R6: storage takes the whole chain as it stood at the storage edge
   a_r6_capture: assert property (@(posedge st_clk) disable iff (!st_rst_n)
      $past(st_rst_n) |-> par_out == $past(sh_q));

   // R5: storage held at zero while its clear is low
   a_r5_store_clear: assert property (@(posedge st_clk)
      !st_clr_n |=> par_out == '0);

   // R4: chain held at zero while its clear is low
   a_r4_shift_clear: assert property (@(posedge sh_clk)
      !sh_clr_n |=> sh_q == '0);

   generate
      if (SYNC_STAGES >= 1) begin : g_sync_chk
         // R9: first edge after release leaves the chain cleared
         a_r9_shift_release: assert property (@(posedge sh_clk)
            !sh_clr_n |=> ##1 sh_q == '0);
         // R9: same for the storage register
         a_r9_store_release: assert property (@(posedge st_clk)
            !st_clr_n |=> ##1 par_out == '0);
      end
   endgenerate
endmodule

bind dualclk_sipo dualclk_sipo_chk #(
   .WIDTH       (WIDTH),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .sh_clk   (sh_clk),
   .st_clk   (st_clk),
   .sh_clr_n (sh_clr_n),
   .st_clr_n (st_clr_n),
   .ser_in   (ser_in),
   .sh_rst_n (sh_rst_n),
   .st_rst_n (st_rst_n),
   .sh_q     (shift_q),
   .par_out  (par_out),
   .cas_out  (cas_out)
);

// File: tb/dualclk_sipo_bench.sv
module dualclk_sipo_bench;
   localparam int CLK_P = 10;
   localparam int HALF  = CLK_P / 2;
   localparam int W     = 8;
   localparam int SYNC  = 2;

   logic         ser_in   = 1'b0;
   logic         sh_clk   = 1'b0;
   logic         st_clk   = 1'b0;
   logic         sh_clr_n = 1'b1;
   logic         st_clr_n = 1'b1;
   logic [W-1:0] par_out;
   logic         cas_out;
   logic [W-1:0] ch_lo_par;
   logic [W-1:0] ch_hi_par;
   logic         ch_mid;
   logic         ch_cas;

   int checks = 0;
   int errors = 0;

   logic [W-1:0]   m_sh  = '0;
   logic [W-1:0]   m_st  = '0;
   logic [2*W-1:0] m_csh = '0;
   logic [2*W-1:0] m_cst = '0;
   int sh_blk = 0;
   int st_blk = 0;

   dualclk_sipo #(.WIDTH(W), .SYNC_STAGES(SYNC)) u_dualclk_sipo (
      .ser_in(ser_in), .sh_clk(sh_clk), .sh_clr_n(sh_clr_n),
      .st_clk(st_clk), .st_clr_n(st_clr_n), .par_out(par_out), .cas_out(cas_out)
   );

   dualclk_sipo #(.WIDTH(W), .SYNC_STAGES(SYNC)) u_chain_lo (
      .ser_in(ser_in), .sh_clk(sh_clk), .sh_clr_n(sh_clr_n),
      .st_clk(st_clk), .st_clr_n(st_clr_n), .par_out(ch_lo_par), .cas_out(ch_mid)
   );

   dualclk_sipo #(.WIDTH(W), .SYNC_STAGES(SYNC)) u_chain_hi (
      .ser_in(ch_mid), .sh_clk(sh_clk), .sh_clr_n(sh_clr_n),
      .st_clk(st_clk), .st_clr_n(st_clr_n), .par_out(ch_hi_par), .cas_out(ch_cas)
   );

   // ---------------- model bookkeeping ----------------
   task automatic sh_model(input logic d);
      if (sh_clr_n) begin
         if (sh_blk > 0) sh_blk--;
         else begin
            m_sh  = {m_sh[W-2:0], d};
            m_csh = {m_csh[2*W-2:0], d};
         end
      end
   endtask

   task automatic st_model();
      if (st_clr_n) begin
         if (st_blk > 0) st_blk--;
         else begin
            m_st  = m_sh;
            m_cst = m_csh;
         end
      end
   endtask

   // ---------------- stimulus ----------------
   task automatic pulse_sh(input logic d);
      ser_in = d;
      #(HALF); sh_clk = 1'b1; sh_model(d);
      #(HALF); sh_clk = 1'b0;
   endtask

   task automatic pulse_st();
      #(HALF); st_clk = 1'b1; st_model();
      #(HALF); st_clk = 1'b0;
   endtask

   task automatic pulse_both(input logic d);
      ser_in = d;
      #(HALF); st_clk = 1'b1; sh_clk = 1'b1;
      st_model(); sh_model(d);
      #(HALF); st_clk = 1'b0; sh_clk = 1'b0;
   endtask

   task automatic set_sh_clr(input logic low);
      #(HALF);
      if (low) begin sh_clr_n = 1'b0; m_sh = '0; m_csh = '0; end
      else begin sh_clr_n = 1'b1; sh_blk = SYNC; end
   endtask

   task automatic set_st_clr(input logic low);
      #(HALF);
      if (low) begin st_clr_n = 1'b0; m_st = '0; m_cst = '0; end
      else begin st_clr_n = 1'b1; st_blk = SYNC; end
   endtask

   // ---------------- checks ----------------
   task automatic check_out(input string tag);
      #1;
      checks += 2;
      if (par_out !== m_st) begin
         errors++;
         $display("FAIL %s par_out actual %h expected %h", tag, par_out, m_st);
      end
      if (cas_out !== m_sh[W-1]) begin
         errors++;
         $display("FAIL %s cas_out actual %b expected %b", tag, cas_out, m_sh[W-1]);
      end
   endtask

   task automatic check_chain(input string tag);
      #1;
      checks += 2;
      if ({ch_hi_par, ch_lo_par} !== m_cst) begin
         errors++;
         $display("FAIL %s chain word actual %h expected %h", tag, {ch_hi_par, ch_lo_par}, m_cst);
      end
      if (ch_cas !== m_csh[2*W-1]) begin
         errors++;
         $display("FAIL %s chain cas actual %b expected %b", tag, ch_cas, m_csh[2*W-1]);
      end
   endtask

   task automatic shift_word(input logic [W-1:0] v, input string tag);
      for (int i = W-1; i >= 0; i--) begin
         pulse_sh(v[i]);
         check_out(tag);
      end
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      set_sh_clr(1'b1); set_st_clr(1'b1);
      pulse_sh(1'b1); pulse_st();
      check_out("R1");
      check_chain("R1");
      set_sh_clr(1'b0); set_st_clr(1'b0);
   endtask

   task automatic t_release();
      for (int i = 0; i <= SYNC; i++) begin
         pulse_sh(1'b1);
         check_out("R9");
      end
      for (int i = 0; i <= SYNC; i++) begin
         pulse_st();
         check_out("R9");
      end
   endtask

   task automatic t_shift_store();
      shift_word(8'hA5, "R7");
      check_out("R2");
      pulse_st();
      check_out("R6");
      shift_word(8'h3C, "R2");
      check_out("R6");
      for (int i = 0; i < 4; i++) pulse_sh(i[0]);
      pulse_st();
      check_out("R6");
   endtask

   task automatic t_falling();
      ser_in = 1'b0;
      #(HALF); sh_clk = 1'b1; sh_model(1'b0);
      check_out("R3");
      ser_in = 1'b1;
      #(HALF); sh_clk = 1'b0;
      check_out("R3");
      #(HALF); st_clk = 1'b1; st_model();
      check_out("R3");
      pulse_sh(1'b1);
      #(HALF); st_clk = 1'b0;
      check_out("R3");
   endtask

   task automatic t_sh_clear();
      shift_word(8'hF0, "R2");
      pulse_st();
      set_sh_clr(1'b1);
      check_out("R4");
      pulse_sh(1'b1);
      check_out("R4");
      set_sh_clr(1'b0);
      for (int i = 0; i < SYNC + 3; i++) pulse_sh(1'b1);
      pulse_st();
      check_out("R4");
   endtask

   task automatic t_st_clear();
      shift_word(8'h96, "R2");
      pulse_st();
      check_out("R6");
      set_st_clr(1'b1);
      check_out("R5");
      pulse_sh(1'b0);
      check_out("R5");
      set_st_clr(1'b0);
      for (int i = 0; i < SYNC; i++) pulse_st();
      check_out("R5");
      pulse_st();
      check_out("R5");
   endtask

   task automatic t_tied();
      logic [W-1:0] pat = 8'h6B;
      for (int i = W-1; i >= 0; i--) begin
         pulse_both(pat[i]);
         check_out("R8");
      end
      pulse_st();
      check_out("R8");
   endtask

   task automatic t_chain();
      logic [2*W-1:0] pat = 16'hC3A1;
      for (int i = 2*W-1; i >= 0; i--) begin
         pulse_sh(pat[i]);
         check_chain("R10");
      end
      pulse_st();
      check_chain("R10");
   endtask

   task automatic t_random();
      for (int i = 0; i < 400; i++) begin
         logic d = 1'($urandom % 2);
         case ($urandom % 4)
            0: pulse_sh(d);
            1: pulse_st();
            2: pulse_both(d);
            default: pulse_sh(~d);
         endcase
         check_out("R2");
         if (i % 8 == 0) check_chain("R10");
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1;
      t_reset();
      t_release();
      t_shift_store();
      t_falling();
      t_sh_clear();
      t_st_clear();
      t_tied();
      t_chain();
      t_random();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule